// File: doc/BRIEF.md
# Direct Form II Biquad Section

This block is one second-order recursive filter section for signed fixed-point samples. Each accepted input sample first goes through the two-pole feedback part. That part produces an intermediate value, called the state sample, which enters a two-entry state line. The two-zero feedforward part then reads the same state line and forms the output sample.

Because the feedback part runs first, the state sample can be much larger than the input or the output. For that reason the two state registers are wider than the sample ports. They give extra headroom at the top. Both the state sample and the output saturate at their own widths instead of wrapping. The five coefficients are static inputs in signed fixed point, with `COEF_FRAC` fractional bits. In the default Q2.14 format, pole coefficients down to -2.0 can be represented.

A new sample is offered with `in_valid`. The matching output appears with `out_valid` on the following clock. A synchronous reset empties the filter.

Top module: `df2_biquad`

## Requirements
- R1: While `rst` is high on a clock edge, both state registers and the output register are cleared. After that edge, `out_valid` is 0 and `out_sample` is 0. The first sample after reset is processed as if w[n-1] = w[n-2] = 0.
- R2: For each accepted sample x, the state sample is w = x - a1·w1 - a2·w2. Here w1 and w2 are the two most recent state samples, and a1/a2 are read as signed values scaled by 2^-COEF_FRAC.
- R3: When the state sample falls outside the signed STATE_W range, it is clamped to the nearest limit, +(2^(STATE_W-1)-1) or -2^(STATE_W-1). It never wraps around.
- R4: The output is y = b0·w + b1·w1 + b2·w2. It uses the state sample just computed and the two older entries, with b0/b1/b2 scaled by 2^-COEF_FRAC.
- R5: When the output falls outside the signed DATA_W range, it is clamped to the nearest limit. It never wraps around.
- R6: Each sum of coefficient products is brought back from the coefficient scale once. This is done by adding 2^(COEF_FRAC-1) and then shifting right arithmetically by COEF_FRAC. The result is round to nearest, with exact halves going toward +infinity.
- R7: The state line moves only on a clock edge where `in_valid` is 1. At that edge, w2 takes the old w1 and w1 takes the new state sample. On cycles with `in_valid` at 0, the state is unchanged whatever `in_sample` holds.
- R8: `out_valid` is `in_valid` delayed by one clock. `out_sample` is updated only with `out_valid` and holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | DATA_W | Signed input sample |
| coef_b0 | input | COEF_W | Signed feedforward coefficient for w[n] |
| coef_b1 | input | COEF_W | Signed feedforward coefficient for w[n-1] |
| coef_b2 | input | COEF_W | Signed feedforward coefficient for w[n-2] |
| coef_a1 | input | COEF_W | Signed feedback coefficient for w[n-1] |
| coef_a2 | input | COEF_W | Signed feedback coefficient for w[n-2] |
| out_valid | output | 1 | High one clock after an accepted input |
| out_sample | output | DATA_W | Signed, saturated output sample |

## Verification
The bench builds the section with DATA_W=8, COEF_W=8, COEF_FRAC=6 and STATE_W=12. At these widths every possible input code can be swept for each coefficient set, and both saturation limits can be reached within a handful of samples. A coefficient of -2.0 drives the state sample into its clamp quickly, and a gain near 2.0 pushes the output past its 8-bit range. Rounding ties can be placed exactly on the half step by choosing inputs by hand. Idle gaps with changing data on `in_sample` show that the state line waits for the next accepted sample.

// File: rtl/df2_pkg.sv
package df2_pkg;

    // Wide signed working type for products and sums before narrowing.
    localparam int unsigned WORK_W = 64;
    typedef logic signed [WORK_W-1:0] work_t;

    // Add half an LSB of the target scale, then shift arithmetically.
    function automatic work_t scale_round(work_t v, int unsigned frac);
        work_t half;
        if (frac == 0) begin
            half = '0;
        end else begin
            half = work_t'(1) <<< (frac - 1);
        end
        return (v + half) >>> frac;
    endfunction

    // Clamp to the range of a signed number of the given width.
    function automatic work_t clamp_to(work_t v, int unsigned width);
        work_t hi;
        work_t lo;
        hi = (work_t'(1) <<< (width - 1)) - work_t'(1);
        lo = -hi - work_t'(1);
        if (v > hi) begin
            return hi;
        end
        if (v < lo) begin
            return lo;
        end
        return v;
    endfunction

endpackage

// File: rtl/df2_pole_stage.sv
// Feedback summer: state sample = x - a1*w1 - a2*w2, rounded and clamped.
module df2_pole_stage
    import df2_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned COEF_W    = 16,
    parameter int unsigned COEF_FRAC = 14,
    parameter int unsigned STATE_W   = 32
) (
    input  logic signed [DATA_W-1:0]  x_in,
    input  logic signed [COEF_W-1:0]  a1,
    input  logic signed [COEF_W-1:0]  a2,
    input  logic signed [STATE_W-1:0] w1,
    input  logic signed [STATE_W-1:0] w2,
    output logic signed [STATE_W-1:0] w_out
);

    work_t x_scaled;
    work_t fb1;
    work_t fb2;
    work_t sum;
    work_t narrowed;

    always_comb begin
        // Input is lifted onto the coefficient scale before the sum.
        x_scaled = work_t'(x_in) <<< COEF_FRAC;
        fb1      = work_t'(a1) * work_t'(w1);
        fb2      = work_t'(a2) * work_t'(w2);
        sum      = x_scaled - fb1 - fb2;
        narrowed = clamp_to(scale_round(sum, COEF_FRAC), STATE_W);
        w_out    = narrowed[STATE_W-1:0];
    end

endmodule

// File: rtl/df2_zero_stage.sv
// Feedforward summer: y = b0*w0 + b1*w1 + b2*w2, rounded and clamped.
module df2_zero_stage
    import df2_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned COEF_W    = 16,
    parameter int unsigned COEF_FRAC = 14,
    parameter int unsigned STATE_W   = 32
) (
    input  logic signed [STATE_W-1:0] w0,
    input  logic signed [STATE_W-1:0] w1,
    input  logic signed [STATE_W-1:0] w2,
    input  logic signed [COEF_W-1:0]  b0,
    input  logic signed [COEF_W-1:0]  b1,
    input  logic signed [COEF_W-1:0]  b2,
    output logic signed [DATA_W-1:0]  y_out
);

    localparam int unsigned TAPS = 3;

    logic signed [STATE_W-1:0] tap_w [TAPS];
    logic signed [COEF_W-1:0]  tap_b [TAPS];
    work_t                     prod  [TAPS];
    work_t                     sum;
    work_t                     narrowed;

    assign tap_w[0] = w0;
    assign tap_w[1] = w1;
    assign tap_w[2] = w2;
    assign tap_b[0] = b0;
    assign tap_b[1] = b1;
    assign tap_b[2] = b2;

    // One multiplier per tap.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign prod[t] = work_t'(tap_b[t]) * work_t'(tap_w[t]);
    end

    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum = sum + prod[t];
        end
        narrowed = clamp_to(scale_round(sum, COEF_FRAC), DATA_W);
        y_out    = narrowed[DATA_W-1:0];
    end

endmodule

// File: rtl/df2_state_line.sv
// The single shared state line, shifted only on accepted samples.
module df2_state_line #(
    parameter int unsigned STATE_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift,
    input  logic signed [STATE_W-1:0] w_in,
    output logic signed [STATE_W-1:0] w1,
    output logic signed [STATE_W-1:0] w2
);

    localparam int unsigned DEPTH = 2;

    typedef struct packed {
        logic [DEPTH-1:0][STATE_W-1:0] tap;
    } line_t;

    line_t line_d;
    line_t line_q;

    always_comb begin
        line_d = line_q;
        if (shift) begin
            line_d.tap[0] = w_in;
            for (int i = 1; i < DEPTH; i++) begin
                line_d.tap[i] = line_q.tap[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign w1 = line_q.tap[0];
    assign w2 = line_q.tap[1];

endmodule

// File: rtl/df2_biquad.sv
// Second-order section: the pole stage feeds the state line, and the zero stage reads it.
module df2_biquad
    import df2_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned COEF_W    = 16,
    parameter int unsigned COEF_FRAC = 14,
    parameter int unsigned STATE_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic signed [COEF_W-1:0] coef_b0,
    input  logic signed [COEF_W-1:0] coef_b1,
    input  logic signed [COEF_W-1:0] coef_b2,
    input  logic signed [COEF_W-1:0] coef_a1,
    input  logic signed [COEF_W-1:0] coef_a2,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] sample;
    } out_reg_t;

    logic signed [STATE_W-1:0] w_new;
    logic signed [STATE_W-1:0] w1_q;
    logic signed [STATE_W-1:0] w2_q;
    logic signed [DATA_W-1:0]  y_new;

    out_reg_t out_d;
    out_reg_t out_q;

    df2_pole_stage #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC),
        .STATE_W  (STATE_W)
    ) u_pole (
        .x_in (in_sample),
        .a1   (coef_a1),
        .a2   (coef_a2),
        .w1   (w1_q),
        .w2   (w2_q),
        .w_out(w_new)
    );

    df2_state_line #(
        .STATE_W(STATE_W)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .shift(in_valid),
        .w_in (w_new),
        .w1   (w1_q),
        .w2   (w2_q)
    );

    df2_zero_stage #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC),
        .STATE_W  (STATE_W)
    ) u_zero (
        .w0   (w_new),
        .w1   (w1_q),
        .w2   (w2_q),
        .b0   (coef_b0),
        .b1   (coef_b1),
        .b2   (coef_b2),
        .y_out(y_new)
    );

    // Output register: a new sample is loaded only together with a valid strobe.
    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.sample = y_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign out_sample = out_q.sample;

endmodule

// File: rtl/df2_biquad_chk.sv
module df2_biquad_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned STATE_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic                      out_valid,
    input logic signed [DATA_W-1:0]  out_sample,
    input logic signed [STATE_W-1:0] st1,
    input logic signed [STATE_W-1:0] st2
);

    // R1: reset empties the state line and the output register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0 && st1 == '0 && st2 == '0));

    // R8: the strobe follows the input strobe one clock later
    a_r8_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8: no output strobe without an accepted input
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: the output sample holds between accepted inputs
    a_r8_hold_sample: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    // R7: the state line is frozen on idle cycles
    a_r7_state_frozen: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(st1) && $stable(st2)));

    // R7: an accepted sample moves the newer entry into the older slot
    a_r7_state_shift: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (st2 == $past(st1)));

endmodule

bind df2_biquad df2_biquad_chk #(
    .DATA_W (DATA_W),
    .STATE_W(STATE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sample(out_sample),
    .st1       (w1_q),
    .st2       (w2_q)
);

// File: tb/df2_biquad_bench.sv
module df2_biquad_bench;

    localparam int DW = 8;
    localparam int CW = 8;
    localparam int F  = 6;
    localparam int SW = 12;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic signed [CW-1:0] b0 = '0, b1 = '0, b2 = '0, a1 = '0, a2 = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_sample;

    int checks   = 0;
    int failures = 0;

    // Reference state and the last output, computed from the requirements.
    longint mw1 = 0, mw2 = 0;
    longint last_y = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    df2_biquad #(
        .DATA_W(DW), .COEF_W(CW), .COEF_FRAC(F), .STATE_W(SW)
    ) u_df2_biquad (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef_b0(b0), .coef_b1(b1), .coef_b2(b2), .coef_a1(a1), .coef_a2(a2),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic longint rnd(longint v);
        return (v + (longint'(1) <<< (F - 1))) >>> F;
    endfunction

    function automatic longint sat(longint v, int w);
        longint hi, lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        mw1 = 0; mw2 = 0; last_y = 0;
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 out_sample after reset", longint'(out_sample), 0);
    endtask

    task automatic set_coefs(int cb0, int cb1, int cb2, int ca1, int ca2);
        b0 = CW'(cb0); b1 = CW'(cb1); b2 = CW'(cb2);
        a1 = CW'(ca1); a2 = CW'(ca2);
    endtask

    // Accept one sample; returns the output expected from the model.
    task automatic push(int x, string req, output longint y_exp);
        longint w;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DW'(x);
        w = sat(rnd((longint'(x) <<< F) - longint'(a1) * mw1 - longint'(a2) * mw2), SW);
        y_exp = sat(rnd(longint'(b0) * w + longint'(b1) * mw1 + longint'(b2) * mw2), DW);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check("R8 out_valid after accepted sample", longint'(out_valid), 1);
        check(req, longint'(out_sample), y_exp);
        mw2 = mw1; mw1 = w; last_y = y_exp;
    endtask

    // Idle cycles with changing data on in_sample: nothing may move (R7, R8).
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_sample = DW'(lfsr);
            @(posedge clk);
            #1;
            check("R8 out_valid low when idle", longint'(out_valid), 0);
            check("R7/R8 output held when idle", longint'(out_sample), last_y);
        end
    endtask

    task automatic sweep(bit descending);
        longint y;
        for (int i = 0; i < 256; i++) begin
            int x;
            x = descending ? (127 - i) : (i - 128);
            push(x, "R2/R4/R6 sweep output", y);
            if (i % 29 == 5) idle(2);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        longint y;
        repeat (3) @(posedge clk);
        #1;
        // R1: state cleared at power-up reset
        check("R1 out_valid in reset", longint'(out_valid), 0);
        do_reset();

        // R6: rounding ties toward +inf with b0 = 1/64, no feedback
        set_coefs(1, 0, 0, 0, 0);
        push(32, "R6 half rounds up", y);   check("R6 tie +0.5", y, 1);
        push(31, "R6 below half", y);       check("R6 below half", y, 0);
        push(-32, "R6 negative tie", y);    check("R6 tie -0.5", y, 0);
        push(-33, "R6 past negative tie", y); check("R6 below -0.5", y, -1);

        // R3: a1 = -2.0 drives the state sample into its clamp
        do_reset();
        set_coefs(1, 0, 0, -128, 0);
        for (int k = 0; k < 6; k++) push(127, "R3 state clamp high", y);
        check("R3 high clamp gives 2047/64 rounded", y, 32);
        push(127, "R3 stays clamped", y);
        check("R3 no wrap on repeat", y, 32);
        do_reset();
        for (int k = 0; k < 6; k++) push(-128, "R3 state clamp low", y);
        check("R3 low clamp gives -2048/64", y, -32);

        // R5: output gain near 2.0 overflows the 8-bit output
        do_reset();
        set_coefs(127, 0, 0, 0, 0);
        push(127, "R5 output clamp high", y);  check("R5 high limit", y, 127);
        push(-128, "R5 output clamp low", y);  check("R5 low limit", y, -128);
        push(10, "R5 in range", y);            check("R5 unclamped", y, 20);

        // R2/R4/R7: full-range sweeps over several coefficient sets with idle gaps
        do_reset(); set_coefs(64, 0, 0, 0, 0);       sweep(1'b0);
        do_reset(); set_coefs(16, 32, 16, -64, 16);  sweep(1'b0);
        do_reset(); set_coefs(32, -64, 32, 40, 20);  sweep(1'b1);
        do_reset(); set_coefs(64, 64, 64, -127, 63); sweep(1'b0);
        do_reset(); set_coefs(-90, 127, -128, 100, -50); sweep(1'b1);
        for (int s = 0; s < 4; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_reset();
            set_coefs(int'($signed(lfsr[7:0])), int'($signed(lfsr[15:8])),
                      int'($signed(lfsr[11:4])), int'($signed(lfsr[9:2])) / 2,
                      int'($signed(lfsr[13:6])) / 2);
            sweep(s[0]);
        end

        // R1: a reset in mid-stream restarts from an empty state
        do_reset();
        set_coefs(16, 32, 16, -64, 16);
        push(100, "R1 first sample after reset", y);
        check("R1 zero-state response", y, 25);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule